// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence for a four-beat burst on a synchronous SRAM. When the chip is enabled and the active-low address strobe is sampled low at a rising clock edge, the block stores the presented address as the start of a new burst. The beat counter also returns to zero at that edge.

On each later edge where the advance input is high, the burst moves one beat forward. When advance is low, the current beat and address are held. The two low address bits are derived from the stored start bits and the beat number, and the `order_sel` input chooses how. In linear order the block adds the beat to the start bits, modulo four. In interleaved order it XORs the beat into the start bits. After the fourth beat the sequence returns to the start address. The upper address bits always come straight from the stored start address.

The outputs are the full burst address, the beat index, and a flag that marks the last beat. Storage, byte-write control and chip-enable decoding belong to the surrounding logic.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the stored address and the beat index are cleared. On the next cycle `burst_addr` is 0, `beat_idx` is 0 and `final_beat` is 0.
- R2: A load happens at an edge where `chip_en` is 1 and `strobe_n` is 0. After the edge, `start_addr` is stored and `beat_idx` is 0. With beat 0, `burst_addr` equals the loaded address in both orders.
- R3: When `strobe_n` is 0 but `chip_en` is 0, there is no load. The stored address and the beat index are unchanged, apart from any step taken because of `advance`.
- R4: At an edge with no load and `advance` equal to 1, `beat_idx` increases by 1, modulo 4.
- R5: At an edge with no load and `advance` equal to 0, `beat_idx` and `burst_addr` stay unchanged.
- R6: When `order_sel` is 0 (linear), `burst_addr[1:0]` equals (stored start bits [1:0] + `beat_idx`) mod 4.
- R7: When `order_sel` is 1 (interleaved), `burst_addr[1:0]` equals stored start bits [1:0] XOR `beat_idx`.
- R8: A step taken from beat 3 returns `beat_idx` to 0, and `burst_addr` returns to the loaded start address.
- R9: `burst_addr[ADDR_W-1:2]` always equals bits [ADDR_W-1:2] of the last loaded address.
- R10: If a load and `advance` fall on the same edge, the load wins and `beat_idx` becomes 0.
- R11: `final_beat` is 1 exactly when `beat_idx` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip enables active, already decoded |
| strobe_n | input | 1 | Address strobe, active low |
| advance | input | 1 | Step the burst one beat when high |
| order_sel | input | 1 | 0 = linear, 1 = interleaved |
| start_addr | input | ADDR_W | Address presented at a load |
| burst_addr | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Beat number, 0 to 3 |
| final_beat | output | 1 | High on beat 3 |

## Verification
Directed bursts are run from every start offset in both orders. The offsets 1 and 3 give different sequences under addition and under XOR, so these cases separate the two orders. Offset 0 gives the same sequence in both orders and so exposes a wrong wrap or a wrong counter.

Further directed cases cover a load and an advance on the same edge, a strobe while the chip is disabled, and long runs with advance held low. These cases separate load priority, gating of the strobe by `chip_en`, and suspension of the burst. A seeded random mix then toggles strobe, enable, advance and order on every cycle, so that steps, holds and reloads are interleaved at any beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_start_reg.sv
module bseq_start_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (load) base_q <= addr_in;
  end

  // R2
  base_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> base_q == $past(addr_in));

  // R3
  base_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(base_q));
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (rst)       beat_q <= '0;
    else if (load) beat_q <= '0;
    else if (step) beat_q <= BEAT_W'(beat_q + 1'b1);
  end

  // R4
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> beat_q == BEAT_W'($past(beat_q) + 1'b1));

  // R5
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(beat_q));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (load && step) |=> beat_q == '0);
endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  input  logic              order_sel,
  output logic [BEAT_W-1:0] low_out
);
  import burst_seq_pkg::*;

  function automatic logic [BEAT_W-1:0] linear_low(
      input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] b);
    return BEAT_W'(s + b);
  endfunction

  function automatic logic [BEAT_W-1:0] xor_low(
      input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] b);
    return s ^ b;
  endfunction

  order_e ord;
  assign ord = order_e'(order_sel);

  always_comb begin
    case (ord)
      ORD_INTERLEAVE: low_out = xor_low(start_low, beat);
      default:        low_out = linear_low(start_low, beat);
    endcase
  end

  // R2
  always_comb begin
    if (beat == '0) beat0_start_chk: assert (low_out == start_low);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W    = 20,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  logic              strobe_n,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [1:0]        beat_idx,
  output logic              final_beat
);
  localparam int BEAT_W = $clog2(BURST_LEN);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

  logic              load_ev;
  logic              step_ev;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_bits;
  logic              wrap_ev;

  assign load_ev = chip_en && !strobe_n;
  assign step_ev = advance;
  assign wrap_ev = step_ev && !load_ev && (beat_q == LAST);

  bseq_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk(clk), .rst(rst), .load(load_ev), .addr_in(start_addr), .base_q(base_q)
  );

  bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk(clk), .rst(rst), .load(load_ev), .step(step_ev), .beat_q(beat_q)
  );

  bseq_order #(.BEAT_W(BEAT_W)) u_ord (
    .start_low(base_q[BEAT_W-1:0]), .beat(beat_q),
    .order_sel(order_sel), .low_out(low_bits)
  );

  assign burst_addr = {base_q[ADDR_W-1:BEAT_W], low_bits};
  assign beat_idx   = 2'(beat_q);
  assign final_beat = (beat_q == LAST);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (burst_addr == '0 && beat_idx == 2'd0 && !final_beat));

  // R8
  wrap_start_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_ev |=> (burst_addr == base_q && beat_idx == 2'd0));

  // R9
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load_ev |=> $stable(burst_addr[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chip_en = 1'b0, strobe_n = 1'b1, advance = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] burst_addr;
  logic [1:0]    beat_idx;
  logic          final_beat;

  int n_run = 0;
  int n_fail = 0;
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .chip_en(chip_en), .strobe_n(strobe_n),
    .advance(advance), .order_sel(order_sel), .start_addr(start_addr),
    .burst_addr(burst_addr), .beat_idx(beat_idx), .final_beat(final_beat)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, int beat, logic ord);
    int s = int'(b[1:0]);
    int lo = ord ? (s ^ beat) : ((s + beat) % 4);
    logic [AW-1:0] r = b;
    r[1:0] = 2'(lo);
    return r;
  endfunction

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " addr"}, burst_addr, exp_addr(m_base, m_beat, order_sel));
    chk({tag, " beat"}, AW'(beat_idx), AW'(m_beat));
    chk({tag, " R11 last"}, AW'(final_beat), AW'(m_beat == 3));
  endtask

  // Applies one cycle: drive at the falling edge, update the model at the rising edge, sample 1 ns later.
  task automatic cyc(logic ce, logic sn, logic adv, logic ord, logic [AW-1:0] a);
    @(negedge clk);
    chip_en = ce; strobe_n = sn; advance = adv; order_sel = ord; start_addr = a;
    @(posedge clk);
    if (ce && !sn) begin m_base = a; m_beat = 0; end
    else if (adv) m_beat = (m_beat + 1) % 4;
    #1;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] hold_a;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    chk("R1 zero", burst_addr, '0);
    @(negedge clk); rst = 1'b0;

    // R6 R7 R8: every start offset in both orders, full burst plus wrap
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(1, 0, 0, o[0], AW'(32'h5A3C0 + s));
        check_all("R2 load");
        chk("R2 start", burst_addr, AW'(32'h5A3C0 + s));
        for (int k = 0; k < 4; k++) begin
          cyc(0, 1, 1, o[0], '0);
          check_all(o ? "R7 step" : "R6 step");
        end
        chk("R8 wrap", burst_addr, AW'(32'h5A3C0 + s));
      end
    end

    // R5: suspend
    cyc(1, 0, 0, 1, AW'(32'hABCD1));
    cyc(0, 1, 1, 1, '0);
    hold_a = burst_addr;
    for (int k = 0; k < 5; k++) begin
      cyc(0, 1, 0, 1, AW'(32'hFFFFF));
      chk("R5 hold", burst_addr, hold_a);
    end

    // R3: strobe with chip disabled
    cyc(0, 0, 0, 1, AW'(32'h12345));
    chk("R3 ignored", burst_addr, hold_a);
    check_all("R3 model");

    // R10: load and advance together
    cyc(0, 1, 1, 0, '0);
    cyc(1, 0, 1, 0, AW'(32'h00777));
    chk("R10 beat", AW'(beat_idx), '0);
    check_all("R10 model");

    // Random mix (R4 R5 R6 R7 R9 R11)
    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r = $urandom();
      cyc(r[0], !(r[1] && r[2]), r[3], r[4], AW'($urandom()));
      check_all("R4 R9 rand");
      chk("R9 upper", burst_addr[AW-1:2], m_base[AW-1:2]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule